// File: doc/BRIEF.md
# External Bus Access Steering Controller

This block sits between a CPU core's single memory request port and a multiplexed external address/data bus. For each request it decodes the address and picks where the access goes. Internal ROM, internal RAM and the 256-byte special-register page at 0xFF00..0xFFFF are served by the on-chip arrays through a simple request/return port. Everything else goes to the external bus, and so does a 16-byte window at 0xFFD0..0xFFDF inside the special-register page that is reserved for off-chip registers. An on-chip region always wins over any external device that decodes the same address.

External cycles are sequenced as follows. An address phase drives the address and pulses the address-latch strobe. A data phase follows, with the read or write strobe held for one base clock plus a programmable number of wait clocks. The cycle ends with one recovery clock, in which the strobes are released and the CPU receives a one-clock done pulse. A two-bit wait code selects 0, 1 or 2 wait clocks, or a ready mode that stretches the data phase while an external hold input stays high. A fast-fetch configuration bit decides how internal ROM instruction fetches behave when expansion is on. When the bit is 0, the fetch is shown on the bus as a normal external read cycle, but the data on the bus is ignored and the instruction byte comes from internal ROM.

Top module: `ext_bus_steer`

## Requirements
- R1: An access to an address in internal ROM (0..ROM_SIZE-1), internal RAM (RAM_BASE..RAM_BASE+RAM_SIZE-1) or the special-register page (0xFF00..0xFFFF, excluding the window in R2) is served internally. It raises `int_req` for exactly one clock, raises `int_we` only for writes to RAM or the special-register page, and gives `rsp_done` two clocks after the accepting edge, with the read value taken from `int_rdata`.
- R2: With `cfg_expand`=1, an access to 0xFFD0..0xFFDF runs an external bus cycle. The neighbouring addresses 0xFFCF and 0xFFE0 stay internal.
- R3: During an internally served access, `bus_ale`, `bus_rd`, `bus_wr` and `bus_ad_oe` all stay 0.
- R4: With `cfg_expand`=1 and `cfg_fast_fetch`=0, an instruction fetch (`req_fetch`=1, read) from internal ROM runs a full external read cycle with the address strobe and the read strobe. The returned byte is the internal ROM value and not `bus_ad_in`. A data read from ROM, or a fetch with `cfg_expand`=0, stays internal.
- R5: With `cfg_fast_fetch`=1, an internal ROM fetch is served internally, with no strobes.
- R6: While `bus_rd` is 1, `bus_ad_oe` is 0.
- R7: Wait code `cfg_wait` values 0, 1 and 2 give a read/write strobe of 1, 2 and 3 clocks. `rsp_done` comes 3, 4 and 5 clocks after the accepting edge.
- R8: Wait code 3 is ready mode: the data phase lasts one clock, plus one clock for every data-phase clock that ends with `ext_hold`=1.
- R9: An external cycle is `bus_ale` for one clock, then the strobe, then one recovery clock with all strobes low and `rsp_done`=1 for exactly one clock. Out of reset, `req_ready`=1 and all strobes are 0.
- R10: A write to an internal ROM address changes nothing. It raises no `int_req`, no `int_we` and no `bus_wr`, and completes in two clocks.
- R11: During the address phase, `bus_addr_hi` carries the address bits above DATA_W and `bus_ad_out` carries the low bits, with `bus_ad_oe`=1. An external write drives `req_wdata` on `bus_ad_out` with `bus_ad_oe`=1 while `bus_wr` is 1. An external read returns `bus_ad_in` as sampled in the last data-phase clock.
- R12: With `cfg_expand`=0, an access to an address outside the internal regions, including the 0xFFD0 window, makes no strobe and no `int_req`, and completes in two clocks with all-ones read data.
- R13: A request presented while `req_ready`=0 is dropped and never starts a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request, accepted when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| cfg_expand | input | 1 | External expansion enabled |
| cfg_fast_fetch | input | 1 | 0 = show internal ROM fetches as bus cycles |
| cfg_wait | input | WCODE_W | Wait code: 0..2 wait clocks, all-ones = ready mode |
| ext_hold | input | 1 | External hold request for ready mode |
| int_req | output | 1 | Internal array access strobe |
| int_we | output | 1 | Internal array write enable |
| int_addr | output | ADDR_W | Internal array address |
| int_wdata | output | DATA_W | Internal array write data |
| int_rdata | input | DATA_W | Internal array read data, valid the clock after int_req |
| bus_ale | output | 1 | Address-latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr_hi | output | ADDR_W-DATA_W | Upper address lines |
| bus_ad_out | output | DATA_W | Multiplexed address/data output |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_ad_in | input | DATA_W | Multiplexed address/data input |

## Verification
A wrong region decision shows up at once. The clock after the accepting edge has either `bus_ale` high where `int_req` alone was due, or the reverse, and completion moves by at least one clock. A wrong wait-counter load or a stuck ready flag changes the strobe length and the done clock of that same access. A bad sequencer state shows as overlapping strobes, a missing recovery clock or a double done pulse within the cycle. Errors in the data path appear in the returned byte of the access in progress, for example bus data leaking into an imitated ROM fetch.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   // fixed special-register page and the off-chip window inside it
   localparam int unsigned SFR_BASE   = 32'h0000_FF00;
   localparam int unsigned SFR_SPAN   = 32'd256;
   localparam int unsigned XWIN_BASE  = 32'h0000_FFD0;
   localparam int unsigned XWIN_SPAN  = 32'd16;

   typedef enum logic [2:0] {
      RG_ROM,
      RG_RAM,
      RG_SFR,
      RG_EXT,
      RG_NONE
   } region_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_DATA,
      ST_RECOV,
      ST_INT,
      ST_IDONE
   } state_e;

endpackage

// File: rtl/ebs_decode.sv
module ebs_decode
   import ebs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned ROM_SIZE = 32'h8000,
   parameter int unsigned RAM_BASE = 32'hFD00,
   parameter int unsigned RAM_SIZE = 32'h0200
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              expand,
   output region_e           region
);

   localparam int unsigned LW = ADDR_W + 1;
   localparam logic [LW-1:0] ROM_LIM = LW'(ROM_SIZE);
   localparam logic [LW-1:0] RAM_LO  = LW'(RAM_BASE);
   localparam logic [LW-1:0] RAM_LIM = LW'(RAM_BASE + RAM_SIZE);
   localparam logic [LW-1:0] SFR_LO  = LW'(SFR_BASE);
   localparam logic [LW-1:0] SFR_LIM = LW'(SFR_BASE + SFR_SPAN);
   localparam logic [LW-1:0] WIN_LO  = LW'(XWIN_BASE);
   localparam logic [LW-1:0] WIN_LIM = LW'(XWIN_BASE + XWIN_SPAN);

   logic [LW-1:0] a_x;
   logic          in_rom, in_ram, in_sfr, in_win;

   assign a_x = {1'b0, addr};

   generate
      if (ROM_SIZE == 0) begin : g_no_rom
         assign in_rom = 1'b0;
      end else begin : g_rom
         assign in_rom = (a_x < ROM_LIM);
      end
      if (RAM_SIZE == 0) begin : g_no_ram
         assign in_ram = 1'b0;
      end else begin : g_ram
         assign in_ram = (a_x >= RAM_LO) && (a_x < RAM_LIM);
      end
   endgenerate

   assign in_sfr = (a_x >= SFR_LO)  && (a_x < SFR_LIM);
   assign in_win = (a_x >= WIN_LO)  && (a_x < WIN_LIM);

   // internal regions win over anything off-chip, except the window
   always_comb begin
      if (in_win)       region = expand ? RG_EXT : RG_NONE;
      else if (in_rom)  region = RG_ROM;
      else if (in_ram)  region = RG_RAM;
      else if (in_sfr)  region = RG_SFR;
      else              region = expand ? RG_EXT : RG_NONE;
   end

endmodule

// File: rtl/ebs_wait.sv
module ebs_wait #(
   parameter int unsigned WCODE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [WCODE_W-1:0] code,
   input  logic               active,
   input  logic               ext_hold,
   output logic               last
);

   localparam logic [WCODE_W-1:0] READY_CODE = '1;

   logic [WCODE_W-1:0] cnt;
   logic               ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ready_q <= 1'b0;
      end else if (load) begin
         cnt     <= (code == READY_CODE) ? '0 : code;
         ready_q <= (code == READY_CODE);
      end else if (active && (cnt != '0)) begin
         cnt     <= cnt - WCODE_W'(1);
      end
   end

   assign last = active && (cnt == '0) && !(ready_q && ext_hold);

endmodule

// File: rtl/ebs_fsm.sv
module ebs_fsm
   import ebs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    req_write,
   input  logic    req_fetch,
   input  logic    expand,
   input  logic    fast_fetch,
   input  region_e region,
   input  logic    wait_last,
   output state_e  state,
   output logic    accept,
   output logic    wait_load,
   output logic    data_end,
   output logic    emul
);

   state_e state_n;
   logic   emul_d, go_ext;

   assign accept    = (state == ST_IDLE) && req_valid;
   assign emul_d    = (region == RG_ROM) && req_fetch && !req_write &&
                      expand && !fast_fetch;
   assign go_ext    = (region == RG_EXT) || emul_d;
   assign wait_load = (state == ST_ADDR);
   assign data_end  = (state == ST_DATA) && wait_last;

   always_comb begin
      state_n = state;
      case (state)
         ST_IDLE:  if (accept) state_n = go_ext ? ST_ADDR : ST_INT;
         ST_ADDR:  state_n = ST_DATA;
         ST_DATA:  if (wait_last) state_n = ST_RECOV;
         ST_RECOV: state_n = ST_IDLE;
         ST_INT:   state_n = ST_IDONE;
         ST_IDONE: state_n = ST_IDLE;
         default:  state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         emul  <= 1'b0;
      end else begin
         state <= state_n;
         if (accept) emul <= emul_d;
      end
   end

endmodule

// File: rtl/ext_bus_steer.sv
module ext_bus_steer
   import ebs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ROM_SIZE = 32'h8000,
   parameter int unsigned RAM_BASE = 32'hFD00,
   parameter int unsigned RAM_SIZE = 32'h0200,
   parameter int unsigned WCODE_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic                     req_fetch,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     req_ready,
   output logic                     rsp_done,
   output logic [DATA_W-1:0]        rsp_rdata,
   input  logic                     cfg_expand,
   input  logic                     cfg_fast_fetch,
   input  logic [WCODE_W-1:0]       cfg_wait,
   input  logic                     ext_hold,
   output logic                     int_req,
   output logic                     int_we,
   output logic [ADDR_W-1:0]        int_addr,
   output logic [DATA_W-1:0]        int_wdata,
   input  logic [DATA_W-1:0]        int_rdata,
   output logic                     bus_ale,
   output logic                     bus_rd,
   output logic                     bus_wr,
   output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
   output logic [DATA_W-1:0]        bus_ad_out,
   output logic                     bus_ad_oe,
   input  logic [DATA_W-1:0]        bus_ad_in
);

   localparam int unsigned HI_W = ADDR_W - DATA_W;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 16) begin : g_bad_aw
         $error("ext_bus_steer: ADDR_W must cover the 0xFF00 page");
      end
      if (DATA_W == 0 || DATA_W >= ADDR_W) begin : g_bad_dw
         $error("ext_bus_steer: DATA_W must be 1..ADDR_W-1");
      end
      if (WCODE_W != 2) begin : g_bad_wc
         $error("ext_bus_steer: wait code is two bits");
      end
      if (ROM_SIZE > SFR_BASE || RAM_BASE + RAM_SIZE > SFR_BASE) begin : g_bad_map
         $error("ext_bus_steer: ROM/RAM overlap the register page");
      end
      if (RAM_SIZE != 0 && ROM_SIZE > RAM_BASE) begin : g_bad_ovl
         $error("ext_bus_steer: ROM overlaps RAM");
      end
   endgenerate

   region_e             region, region_q;
   state_e              state;
   logic                accept, wait_load, data_end, emul, wait_last;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q, data_q;
   logic                write_q, in_data, ext_cyc;

   ebs_decode #(
      .ADDR_W  (ADDR_W),
      .ROM_SIZE(ROM_SIZE),
      .RAM_BASE(RAM_BASE),
      .RAM_SIZE(RAM_SIZE)
   ) u_decode (
      .addr  (req_addr),
      .expand(cfg_expand),
      .region(region)
   );

   ebs_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_fetch (req_fetch),
      .expand    (cfg_expand),
      .fast_fetch(cfg_fast_fetch),
      .region    (region),
      .wait_last (wait_last),
      .state     (state),
      .accept    (accept),
      .wait_load (wait_load),
      .data_end  (data_end),
      .emul      (emul)
   );

   assign in_data = (state == ST_DATA);

   ebs_wait #(
      .WCODE_W(WCODE_W)
   ) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wait_load),
      .code    (cfg_wait),
      .active  (in_data),
      .ext_hold(ext_hold),
      .last    (wait_last)
   );

   // request capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         write_q  <= 1'b0;
         region_q <= RG_NONE;
      end else if (accept) begin
         addr_q   <= req_addr;
         wdata_q  <= req_wdata;
         write_q  <= req_write;
         region_q <= region;
      end
   end

   // read capture at the end of the data phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (data_end) data_q <= emul ? int_rdata : bus_ad_in;
   end

   // external bus drive
   assign ext_cyc     = (state == ST_ADDR) || in_data;
   assign bus_ale     = (state == ST_ADDR);
   assign bus_rd      = in_data && !write_q;
   assign bus_wr      = in_data && write_q;
   assign bus_ad_oe   = bus_ale || bus_wr;
   assign bus_addr_hi = ext_cyc ? addr_q[ADDR_W-1:DATA_W] : HI_W'(0);
   assign bus_ad_out  = bus_ale ? addr_q[DATA_W-1:0] :
                        (bus_wr ? wdata_q : '0);

   // internal array port
   assign int_req   = ((state == ST_INT) && (region_q != RG_NONE) &&
                       !(write_q && (region_q == RG_ROM))) ||
                      ((state == ST_ADDR) && emul);
   assign int_we    = (state == ST_INT) && write_q &&
                      ((region_q == RG_RAM) || (region_q == RG_SFR));
   assign int_addr  = addr_q;
   assign int_wdata = wdata_q;

   // CPU return
   assign req_ready = (state == ST_IDLE);
   assign rsp_done  = (state == ST_RECOV) || (state == ST_IDONE);
   assign rsp_rdata = (state == ST_IDONE) ?
                      ((region_q == RG_NONE) ? '1 : int_rdata) : data_q;

endmodule

// File: rtl/ebs_check.sv
module ebs_check #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned ROM_SIZE = 32'h8000,
   parameter int unsigned WCODE_W  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_ale,
   input logic               bus_rd,
   input logic               bus_wr,
   input logic               bus_ad_oe,
   input logic               rsp_done,
   input logic               int_we,
   input logic [ADDR_W-1:0]  int_addr,
   input logic [WCODE_W-1:0] cfg_wait
);

   logic [7:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run <= '0;
      else if (bus_rd || bus_wr)  run <= (run == 8'hFF) ? run : run + 8'd1;
      else                        run <= '0;
   end

   // R6
   rd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> !bus_ad_oe);

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_ale, bus_rd, bus_wr}));

   // R9
   ale_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_rd) || $rose(bus_wr)) |-> $past(bus_ale));

   // R9
   strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd) || $fell(bus_wr)) |-> rsp_done);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R3
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !(bus_ale || bus_rd || bus_wr || bus_ad_oe));

   // R10
   rom_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_we |-> (int_addr >= ADDR_W'(ROM_SIZE)));

   // R7
   data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($fell(bus_rd) || $fell(bus_wr)) && (cfg_wait != '1)) |->
      (run == 8'(cfg_wait) + 8'd1));

endmodule

bind ext_bus_steer ebs_check #(
   .ADDR_W  (ADDR_W),
   .ROM_SIZE(ROM_SIZE),
   .WCODE_W (WCODE_W)
) u_ebs_check (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_ale  (bus_ale),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_ad_oe(bus_ad_oe),
   .rsp_done (rsp_done),
   .int_we   (int_we),
   .int_addr (int_addr),
   .cfg_wait (cfg_wait)
);

// File: tb/test_ext_bus_steer.sv
`timescale 1ns/100ps
module test_ext_bus_steer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_fetch = 0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_done;
   logic [7:0]  rsp_rdata;
   logic        cfg_expand = 1, cfg_fast_fetch = 1;
   logic [1:0]  cfg_wait = 0;
   logic        ext_hold = 0;
   logic        int_req, int_we;
   logic [15:0] int_addr;
   logic [7:0]  int_wdata, int_rdata = '0;
   logic        bus_ale, bus_rd, bus_wr, bus_ad_oe;
   logic [7:0]  bus_addr_hi, bus_ad_out;
   logic [7:0]  bus_ad_in = '0;

   int checks = 0, fails = 0;
   int m_lat, m_ale, m_rd, m_wr, m_oebad, m_ireq, m_iwe, m_extra;
   logic [7:0] m_rdata, m_wseen, m_hi, m_lo;

   always #2.5 clk = ~clk;

   ext_bus_steer i_ext_bus_steer (.*);

   function automatic logic [7:0] mdl(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // internal array model: one-clock read latency, data held
   always @(posedge clk)
      if (int_req && !int_we) int_rdata <= mdl(int_addr);

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_acc(input logic [15:0] a, input logic wr, input logic f,
                         input logic [7:0] wd, input int hold, input bit poke);
      m_lat = 0; m_ale = 0; m_rd = 0; m_wr = 0; m_oebad = 0;
      m_ireq = 0; m_iwe = 0; m_extra = 0;
      m_rdata = '0; m_wseen = '0; m_hi = '0; m_lo = '0;
      @(negedge clk);
      req_valid = 1; req_addr = a; req_write = wr; req_fetch = f; req_wdata = wd;
      ext_hold = (hold != 0);
      @(negedge clk);
      req_valid = 0;
      forever begin
         m_lat++;
         if (bus_ale) begin m_ale++; m_hi = bus_addr_hi; m_lo = bus_ad_out; end
         if (bus_rd) m_rd++;
         if (bus_rd && bus_ad_oe) m_oebad++;
         if (bus_wr) begin m_wr++; if (bus_ad_oe) m_wseen = bus_ad_out; end
         if (int_req) m_ireq++;
         if (int_we) m_iwe++;
         if (hold != 0 && m_rd == hold) ext_hold = 0;
         if (poke && m_lat == 1) begin
            req_valid = 1; req_addr = 16'hFD20; req_write = 0; req_fetch = 0;
         end else req_valid = 0;
         if (rsp_done) begin m_rdata = rsp_rdata; break; end
         if (m_lat > 50) break;
         @(negedge clk);
      end
      req_valid = 0; ext_hold = 0;
      repeat (4) begin
         @(negedge clk);
         if (bus_ale || int_req || rsp_done) m_extra++;
      end
   endtask

   task automatic t_reset();
      check("R9 reset ready", req_ready, 1);
      check("R9 reset strobes", {bus_ale, bus_rd, bus_wr, bus_ad_oe}, 0);
      check("R9 reset done", rsp_done, 0);
   endtask

   task automatic t_internal();
      cfg_expand = 1; cfg_fast_fetch = 1;
      do_acc(16'hFD10, 0, 0, 8'h00, 0, 0);
      check("R1 ram latency", m_lat, 2);
      check("R1 ram int_req", m_ireq, 1);
      check("R1 ram rdata", m_rdata, mdl(16'hFD10));
      check("R3 ram strobes", m_ale + m_rd + m_wr, 0);
      do_acc(16'hFF20, 1, 0, 8'h99, 0, 0);
      check("R1 sfr write we", m_iwe, 1);
      check("R3 sfr write no wr", m_wr + m_ale, 0);
      check("R1 sfr latency", m_lat, 2);
      do_acc(16'h0100, 0, 1, 8'h00, 0, 0);
      check("R5 fast fetch latency", m_lat, 2);
      check("R5 fast fetch no ale", m_ale + m_rd, 0);
      check("R5 fast fetch data", m_rdata, mdl(16'h0100));
   endtask

   task automatic t_window();
      cfg_expand = 1; cfg_wait = 0; bus_ad_in = 8'hA7;
      do_acc(16'hFFD5, 0, 0, 8'h00, 0, 0);
      check("R2 window ale", m_ale, 1);
      check("R2 window rd", m_rd, 1);
      check("R7 window latency", m_lat, 3);
      check("R11 addr hi", m_hi, 8'hFF);
      check("R11 addr lo", m_lo, 8'hD5);
      check("R11 read data", m_rdata, 8'hA7);
      check("R6 oe during rd", m_oebad, 0);
      do_acc(16'hFFCF, 0, 0, 8'h00, 0, 0);
      check("R2 below window internal", m_ale * 16 + m_lat, 2);
      do_acc(16'hFFE0, 0, 0, 8'h00, 0, 0);
      check("R2 above window internal", m_ale * 16 + m_lat, 2);
   endtask

   task automatic t_waits();
      cfg_expand = 1; bus_ad_in = 8'h3E;
      for (int w = 1; w <= 2; w++) begin
         cfg_wait = 2'(w);
         do_acc(16'h9000, 0, 0, 8'h00, 1, 0);
         check("R7 rd length", m_rd, w + 1);
         check("R7 latency", m_lat, w + 3);
         check("R8 hold ignored outside ready mode", m_rd, w + 1);
         check("R11 ext read data", m_rdata, 8'h3E);
         check("R1 no int_req on ext", m_ireq, 0);
      end
      cfg_wait = 2;
      do_acc(16'h9001, 1, 0, 8'h3C, 0, 0);
      check("R7 wr length", m_wr, 3);
      check("R11 write data", m_wseen, 8'h3C);
      check("R9 write latency", m_lat, 5);
   endtask

   task automatic t_ready();
      cfg_expand = 1; cfg_wait = 3;
      do_acc(16'h9100, 0, 0, 8'h00, 4, 0);
      check("R8 held rd length", m_rd, 4);
      check("R8 held latency", m_lat, 6);
      do_acc(16'h9100, 0, 0, 8'h00, 0, 0);
      check("R8 unheld rd length", m_rd, 1);
      check("R8 unheld latency", m_lat, 3);
   endtask

   task automatic t_emul();
      cfg_expand = 1; cfg_fast_fetch = 0; cfg_wait = 1; bus_ad_in = 8'h00;
      do_acc(16'h0123, 0, 1, 8'h00, 0, 0);
      check("R4 emul ale", m_ale, 1);
      check("R4 emul rd", m_rd, 2);
      check("R4 emul latency", m_lat, 4);
      check("R4 emul data from rom", m_rdata, mdl(16'h0123));
      check("R6 emul oe", m_oebad, 0);
      do_acc(16'h0124, 0, 0, 8'h00, 0, 0);
      check("R4 rom data read internal", m_ale * 16 + m_lat, 2);
      cfg_expand = 0;
      do_acc(16'h0125, 0, 1, 8'h00, 0, 0);
      check("R4 no expand fetch internal", m_ale * 16 + m_lat, 2);
      cfg_expand = 1; cfg_fast_fetch = 1;
   endtask

   task automatic t_romwr();
      do_acc(16'h0040, 1, 0, 8'h77, 0, 0);
      check("R10 rom write int_req", m_ireq, 0);
      check("R10 rom write we", m_iwe, 0);
      check("R10 rom write strobes", m_wr + m_ale, 0);
      check("R10 rom write latency", m_lat, 2);
   endtask

   task automatic t_noexp();
      cfg_expand = 0;
      do_acc(16'h9000, 0, 0, 8'h00, 0, 0);
      check("R12 no strobes", m_ale + m_rd + m_ireq, 0);
      check("R12 latency", m_lat, 2);
      check("R12 data", m_rdata, 8'hFF);
      do_acc(16'hFFD0, 0, 0, 8'h00, 0, 0);
      check("R12 window off", m_ale * 16 + m_lat, 2);
      cfg_expand = 1;
   endtask

   task automatic t_busy();
      cfg_wait = 0; bus_ad_in = 8'h11;
      do_acc(16'h9200, 0, 0, 8'h00, 0, 1);
      check("R13 busy request dropped", m_extra, 0);
      check("R13 no int_req", m_ireq, 0);
      check("R13 first cycle intact", m_rdata, 8'h11);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_internal();
      t_window();
      t_waits();
      t_ready();
      t_emul();
      t_romwr();
      t_noexp();
      t_busy();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule